// File: doc/BRIEF.md
# Wakeup Interrupt Capture Latch

This block stands guard over a bank of interrupt lines while the main interrupt controller is powered off. Each line passes through a two-flop synchroniser. Detection then follows that line's own sensitivity and polarity settings, and a qualifying event is held in a per-line pending latch. Software reads the latches later and replays the events to the controller once it is powered up again. The block drives a single wake output whenever a line that is not masked has a pending event.

Every per-line attribute is reached through a word-wide register bus. Each attribute has a read view, plus separate write-one-to-set and write-one-to-clear aliases, so that software can change single lines without a read-modify-write. A control word holds three bits: a global enable, a global edge-only override that forces transition detection on every line, and a self-clearing soft reset. An acknowledge alias lets software drop pending events.

Top module: `wake_capture`

## Requirements
- R1: Each register group holds 32 lines per word. Line n sits at bit n%32 of word n/32. The byte address is group*2^(W+2) + word*4, where W is the width of the word index (1 for 40 lines). The group codes are: 0 control, 1 mask, 2 mask-set, 3 mask-clear, 4 sensitivity, 5 sensitivity-set, 6 sensitivity-clear, 7 polarity, 8 polarity-set, 9 polarity-clear, 10 pending, 11 acknowledge. Set, clear and acknowledge aliases read as 0.
- R2: Writing a 1 to a mask-set bit masks that line, and writing a 1 to a mask-clear bit unmasks it. Bits written as 0 leave their lines unchanged. The mask view reads 1 for a masked line.
- R3: Writing a 1 to a sensitivity-set bit makes that line level sensitive, and writing a 1 to a sensitivity-clear bit makes it edge sensitive. The view reads 1 for level.
- R4: Writing a 1 to a polarity-set bit selects positive polarity (high level or rising edge), and writing a 1 to a polarity-clear bit selects negative polarity. The view reads 1 for positive.
- R5: Control word 0 holds bit 0 enable and bit 1 edge-only. Bit 2 is the soft reset and always reads 0. Clearing enable leaves mask, sensitivity, polarity and pending unchanged.
- R6: For a line in edge mode, the pending bit is visible after the third rising clock edge that follows an input transition in the active direction. A transition in the other direction sets nothing.
- R7: For a line in level mode, every cycle in which the synchronised input is at the active level sets the pending bit.
- R8: While edge-only is set, every line uses edge detection, whatever its sensitivity bit says.
- R9: A masked line, or any line while enable is 0, never sets its pending bit.
- R10: Writing a 1 to an acknowledge bit clears that line's pending bit. If a new event arrives on the same line in the same cycle, the line stays pending.
- R11: At reset, and on a control write with bit 2 set, the block clears every pending bit, enable and edge-only. It also masks all lines and makes them edge sensitive with positive polarity.
- R12: wake is 1 exactly when some line is both pending and unmasked.
- R13: Bits above the last implemented line read 0 in every group and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWe | input | 1 | Register write strobe, one cycle per write |
| busAddr | input | ADDR_W | Byte address (group and word index) |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Combinational read data for busAddr |
| rawIrq | input | NUM_LINES | Asynchronous interrupt lines |
| wake | output | 1 | OR of pending, unmasked lines |

## Verification
A corrupted mask, sensitivity or polarity bit shows on the read bus in the same cycle that its view is addressed. It also changes whether, and three edges after which input transition, the line's pending bit and wake rise. A pending latch that sets or clears wrongly appears on wake, and in the pending view, one cycle after the offending edge. A reference model compares both outputs on every cycle, so any such fault is reported in the cycle it becomes visible.

// File: rtl/wake_cap_pkg.sv
package wake_cap_pkg;

  localparam int GRP_W = 4;

  typedef enum logic [GRP_W-1:0] {
    GRP_CTRL     = 4'd0,
    GRP_MASK     = 4'd1,
    GRP_MASK_SET = 4'd2,
    GRP_MASK_CLR = 4'd3,
    GRP_SENS     = 4'd4,
    GRP_SENS_SET = 4'd5,
    GRP_SENS_CLR = 4'd6,
    GRP_POL      = 4'd7,
    GRP_POL_SET  = 4'd8,
    GRP_POL_CLR  = 4'd9,
    GRP_PEND     = 4'd10,
    GRP_ACK      = 4'd11
  } regGrp_e;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_EDGE_BIT = 1;
  localparam int CTRL_RST_BIT  = 2;

  // strobes from control to the line datapath
  typedef struct packed {
    logic maskSet;
    logic maskClr;
    logic sensSet;
    logic sensClr;
    logic polSet;
    logic polClr;
    logic ack;
    logic swRst;
  } wrStrobe_t;

endpackage

// File: rtl/wake_cap_ctrl.sv
module wake_cap_ctrl
  import wake_cap_pkg::*;
#(
  parameter int WIDX_W = 1,
  parameter int ADDR_W = WIDX_W + 2 + GRP_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output wrStrobe_t         stb,
  output logic [WIDX_W-1:0] wordSel,
  output logic [GRP_W-1:0]  rdGrp,
  output logic              ctrlEnable,
  output logic              ctrlEdgeOnly,
  output logic [31:0]       ctrlRdata
);

  logic ctrlHit;

  assign rdGrp   = busAddr[ADDR_W-1 -: GRP_W];
  assign wordSel = busAddr[2 +: WIDX_W];
  assign ctrlHit = (rdGrp == GRP_CTRL) && (wordSel == '0);

  always_comb begin
    stb = '0;
    if (busWe) begin
      unique case (rdGrp)
        GRP_MASK_SET: stb.maskSet = 1'b1;
        GRP_MASK_CLR: stb.maskClr = 1'b1;
        GRP_SENS_SET: stb.sensSet = 1'b1;
        GRP_SENS_CLR: stb.sensClr = 1'b1;
        GRP_POL_SET:  stb.polSet  = 1'b1;
        GRP_POL_CLR:  stb.polClr  = 1'b1;
        GRP_ACK:      stb.ack     = 1'b1;
        GRP_CTRL:     stb.swRst   = (wordSel == '0) && busWdata[CTRL_RST_BIT];
        default:      stb = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlEnable   <= 1'b0;
      ctrlEdgeOnly <= 1'b0;
    end else if (stb.swRst) begin
      ctrlEnable   <= 1'b0;
      ctrlEdgeOnly <= 1'b0;
    end else if (busWe && ctrlHit) begin
      ctrlEnable   <= busWdata[CTRL_EN_BIT];
      ctrlEdgeOnly <= busWdata[CTRL_EDGE_BIT];
    end
  end

  always_comb begin
    ctrlRdata = '0;
    if (ctrlHit) begin
      ctrlRdata[CTRL_EN_BIT]   = ctrlEnable;
      ctrlRdata[CTRL_EDGE_BIT] = ctrlEdgeOnly;
    end
  end

  // R11: soft reset leaves control bits cleared
  assert_srst_ctrl_R11: assert property (@(posedge clk) disable iff (!rstN)
    stb.swRst |=> (!ctrlEnable && !ctrlEdgeOnly));

  // R5: only a control write changes the control bits
  assert_ctrl_stable_R5: assert property (@(posedge clk) disable iff (!rstN)
    !busWe |=> ($stable(ctrlEnable) && $stable(ctrlEdgeOnly)));

endmodule

// File: rtl/wake_cap_lines.sv
module wake_cap_lines
  import wake_cap_pkg::*;
#(
  parameter int NUM_LINES = 40,
  parameter int WORDS     = (NUM_LINES + 31) / 32,
  parameter int WIDX_W    = 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] rawIrq,
  input  wrStrobe_t            stb,
  input  logic [WIDX_W-1:0]    wordSel,
  input  logic [GRP_W-1:0]     rdGrp,
  input  logic [31:0]          busWdata,
  input  logic                 ctrlEnable,
  input  logic                 ctrlEdgeOnly,
  output logic [31:0]          lineRdata,
  output logic [NUM_LINES-1:0] pendVec,
  output logic [NUM_LINES-1:0] maskVec,
  output logic                 wake
);

  localparam int PAD_W = WORDS * 32;

  logic [NUM_LINES-1:0] syncA, syncB, syncPrev;
  logic [NUM_LINES-1:0] sensVec, polVec, evtVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA    <= '0;
      syncB    <= '0;
      syncPrev <= '0;
    end else begin
      syncA    <= rawIrq;
      syncB    <= syncA;
      syncPrev <= syncB;
    end
  end

  for (genvar gi = 0; gi < NUM_LINES; gi++) begin : gLine
    localparam int WI = gi / 32;
    localparam int BI = gi % 32;
    logic hit, useEdge, edgeSeen, levelSeen;

    assign hit       = (32'(wordSel) == WI) && busWdata[BI];
    assign useEdge   = ctrlEdgeOnly || !sensVec[gi];
    assign edgeSeen  = polVec[gi] ? (syncB[gi] && !syncPrev[gi])
                                  : (!syncB[gi] && syncPrev[gi]);
    assign levelSeen = (syncB[gi] == polVec[gi]);
    assign evtVec[gi] = ctrlEnable && !maskVec[gi] &&
                        (useEdge ? edgeSeen : levelSeen);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        maskVec[gi] <= 1'b1;
        sensVec[gi] <= 1'b0;
        polVec[gi]  <= 1'b1;
        pendVec[gi] <= 1'b0;
      end else if (stb.swRst) begin
        maskVec[gi] <= 1'b1;
        sensVec[gi] <= 1'b0;
        polVec[gi]  <= 1'b1;
        pendVec[gi] <= 1'b0;
      end else begin
        if (stb.maskSet && hit)      maskVec[gi] <= 1'b1;
        else if (stb.maskClr && hit) maskVec[gi] <= 1'b0;
        if (stb.sensSet && hit)      sensVec[gi] <= 1'b1;
        else if (stb.sensClr && hit) sensVec[gi] <= 1'b0;
        if (stb.polSet && hit)       polVec[gi]  <= 1'b1;
        else if (stb.polClr && hit)  polVec[gi]  <= 1'b0;
        pendVec[gi] <= evtVec[gi] || (pendVec[gi] && !(stb.ack && hit));
      end
    end

    // R9: a masked line cannot become pending
    assert_mask_blocks_R9: assert property (@(posedge clk) disable iff (!rstN)
      maskVec[gi] |=> !$rose(pendVec[gi]));
    // R9: nothing becomes pending while disabled
    assert_disable_blocks_R9: assert property (@(posedge clk) disable iff (!rstN)
      !ctrlEnable |=> !$rose(pendVec[gi]));
    // R10: acknowledge clears when no event competes
    assert_ack_clears_R10: assert property (@(posedge clk) disable iff (!rstN)
      (stb.ack && hit && !evtVec[gi]) |=> !pendVec[gi]);
    // R10: a fresh event always lands
    assert_event_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
      (evtVec[gi] && !stb.swRst) |=> pendVec[gi]);
  end

  assign wake = |(pendVec & ~maskVec);

  logic [PAD_W-1:0] padMask, padSens, padPol, padPend;
  assign padMask = PAD_W'(maskVec);
  assign padSens = PAD_W'(sensVec);
  assign padPol  = PAD_W'(polVec);
  assign padPend = PAD_W'(pendVec);

  always_comb begin
    lineRdata = '0;
    if (32'(wordSel) < WORDS) begin
      unique case (rdGrp)
        GRP_MASK: lineRdata = padMask[32*wordSel +: 32];
        GRP_SENS: lineRdata = padSens[32*wordSel +: 32];
        GRP_POL:  lineRdata = padPol[32*wordSel +: 32];
        GRP_PEND: lineRdata = padPend[32*wordSel +: 32];
        default:  lineRdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/wake_capture.sv
module wake_capture
  import wake_cap_pkg::*;
#(
  parameter  int NUM_LINES = 40,
  localparam int WORDS     = (NUM_LINES + 31) / 32,
  localparam int WIDX_W    = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int ADDR_W    = WIDX_W + 2 + GRP_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busWe,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  input  logic [NUM_LINES-1:0] rawIrq,
  output logic                 wake
);

  wrStrobe_t            stb;
  logic [WIDX_W-1:0]    wordSel;
  logic [GRP_W-1:0]     rdGrp;
  logic                 ctrlEnable, ctrlEdgeOnly;
  logic [31:0]          ctrlRdata, lineRdata;
  logic [NUM_LINES-1:0] pendVec, maskVec;

  wake_cap_ctrl #(.WIDX_W(WIDX_W), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .stb(stb), .wordSel(wordSel), .rdGrp(rdGrp),
    .ctrlEnable(ctrlEnable), .ctrlEdgeOnly(ctrlEdgeOnly),
    .ctrlRdata(ctrlRdata)
  );

  wake_cap_lines #(.NUM_LINES(NUM_LINES), .WORDS(WORDS), .WIDX_W(WIDX_W)) uLines (
    .clk(clk), .rstN(rstN), .rawIrq(rawIrq), .stb(stb), .wordSel(wordSel),
    .rdGrp(rdGrp), .busWdata(busWdata), .ctrlEnable(ctrlEnable),
    .ctrlEdgeOnly(ctrlEdgeOnly), .lineRdata(lineRdata), .pendVec(pendVec),
    .maskVec(maskVec), .wake(wake)
  );

  assign busRdata = ctrlRdata | lineRdata;

  // R12: no wake without a pending line
  assert_wake_idle_R12: assert property (@(posedge clk) disable iff (!rstN)
    (pendVec == '0) |-> !wake);

  // R12: wake follows an unmasked pending line
  assert_wake_follows_R12: assert property (@(posedge clk) disable iff (!rstN)
    ((pendVec & ~maskVec) != '0) |-> wake);

endmodule

// File: tb/sim_wake_capture.sv
`timescale 1ns/1ps
module sim_wake_capture;

  localparam int NL = 40;
  localparam int AW = 7;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busWe = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [31:0]   busWdata = '0;
  logic [31:0]   busRdata;
  logic [NL-1:0] rawIrq = '0;
  logic          wake;

  int    vecCount = 0;
  int    errCount = 0;
  string curReq = "R11";
  bit    done = 1'b0;

  wake_capture #(.NUM_LINES(NL)) u0 (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .rawIrq(rawIrq), .wake(wake)
  );

  always #2 clk = ~clk;

  // ---------------- reference model ----------------
  logic [NL-1:0] mMask, mSens, mPol, mPend;
  bit            mEn, mEdge;
  logic [NL-1:0] rawQ[$];

  task automatic model_defaults();
    mMask = '1; mSens = '0; mPol = '1; mPend = '0; mEn = 0; mEdge = 0;
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      model_defaults();
      rawQ.delete();
    end else begin
      logic [NL-1:0] cur, prv, evt;
      int grp, word;
      rawQ.push_front(rawIrq);
      if (rawQ.size() > 4) void'(rawQ.pop_back());
      cur = (rawQ.size() > 2) ? rawQ[2] : '0;
      prv = (rawQ.size() > 3) ? rawQ[3] : '0;
      for (int n = 0; n < NL; n++) begin
        bit trig;
        if (mEdge || !mSens[n]) trig = mPol[n] ? (cur[n] && !prv[n]) : (!cur[n] && prv[n]);
        else trig = (cur[n] == mPol[n]);
        evt[n] = mEn && !mMask[n] && trig;
      end
      grp  = int'(busAddr) >> 3;
      word = int'(busAddr[2]);
      if (busWe && grp == 0 && word == 0 && busWdata[2]) begin
        model_defaults();
      end else begin
        if (busWe && grp == 0 && word == 0) begin
          mEn = busWdata[0]; mEdge = busWdata[1];
        end
        for (int n = 0; n < NL; n++) begin
          bit h;
          h = busWe && (n / 32 == word) && busWdata[n % 32];
          if (h && grp == 2) mMask[n] = 1;
          if (h && grp == 3) mMask[n] = 0;
          if (h && grp == 5) mSens[n] = 1;
          if (h && grp == 6) mSens[n] = 0;
          if (h && grp == 8) mPol[n] = 1;
          if (h && grp == 9) mPol[n] = 0;
          mPend[n] = evt[n] || (mPend[n] && !(h && grp == 11));
        end
      end
    end
  end

  function automatic logic [31:0] exp_rd();
    int grp, word;
    logic [63:0] v;
    grp  = int'(busAddr) >> 3;
    word = int'(busAddr[2]);
    case (grp)
      0: return (word == 0) ? {30'b0, mEdge, mEn} : 32'h0;
      1: v = {24'b0, mMask};
      4: v = {24'b0, mSens};
      7: v = {24'b0, mPol};
      10: v = {24'b0, mPend};
      default: return 32'h0;
    endcase
    return v[32*word +: 32];
  endfunction

  always @(negedge clk) begin
    if (rstN && !done) begin
      logic [31:0] er;
      logic ew;
      er = exp_rd();
      ew = |(mPend & ~mMask);
      vecCount++;
      if (busRdata !== er || wake !== ew) begin
        errCount++;
        $display("FAIL %s addr=%0h rdata=%08h exp=%08h wake=%b exp=%b",
                 curReq, busAddr, busRdata, er, wake, ew);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(int grp, int word, logic [31:0] d);
    step(1);
    busWe = 1; busAddr = AW'((grp << 3) | (word << 2)); busWdata = d;
    step(1);
    busWe = 0;
  endtask

  task automatic look(int grp, int word);
    step(1);
    busAddr = AW'((grp << 3) | (word << 2));
    step(1);
  endtask

  task automatic drive(int line, bit v, int settle);
    step(1);
    rawIrq[line] = v;
    step(settle);
  endtask

  initial begin
    step(3);
    rstN = 1;
    // R11: reset state of every view
    curReq = "R11"; look(0, 0); look(1, 0); look(1, 1); look(4, 0); look(7, 1); look(10, 0);
    // R13: unimplemented bits of word 1 stay 0
    curReq = "R13"; wr(3, 1, 32'hFFFF_FFFF); look(1, 1); wr(2, 1, 32'hFFFF_FF00); look(1, 1);
    // R1, R2: mask aliases, zero bits no effect
    curReq = "R2"; wr(3, 0, 32'h0000_00F0); look(1, 0); wr(2, 0, 32'h0000_0010); look(1, 0);
    look(2, 0); look(3, 0);
    // R3, R4: sensitivity and polarity aliases
    curReq = "R3"; wr(5, 0, 32'h8000_0004); look(4, 0); wr(6, 0, 32'h8000_0000); look(4, 0);
    curReq = "R4"; wr(9, 1, 32'h0000_0081); look(7, 1); wr(8, 1, 32'h0000_0001); look(7, 1);
    // R5: enable after acknowledge-all, control read back
    curReq = "R5"; wr(11, 0, 32'hFFFF_FFFF); wr(11, 1, 32'hFFFF_FFFF);
    wr(0, 0, 32'h7); look(0, 0); wr(0, 0, 32'h3); look(0, 0);
    wr(0, 0, 32'h1); look(0, 0);
    // R6: rising edge on line 0
    curReq = "R6"; wr(3, 0, 32'hFFFF_FFFF); wr(6, 0, 32'hFFFF_FFFF);
    wr(8, 0, 32'hFFFF_FFFF); look(10, 0);
    drive(0, 1, 5); drive(0, 0, 5);
    // R10: acknowledge clears
    curReq = "R10"; wr(11, 0, 32'h1); look(10, 0);
    // R6: negative polarity on line 1, rise ignored, fall caught
    curReq = "R6"; wr(9, 0, 32'h2); drive(1, 1, 5); drive(1, 0, 5); wr(11, 0, 32'h2); look(10, 0);
    // R7: level line 2 keeps re-setting while active
    curReq = "R7"; wr(5, 0, 32'h4); drive(2, 1, 5); wr(11, 0, 32'h4); look(10, 0);
    // R10: event wins over acknowledge while level holds
    curReq = "R10"; wr(11, 0, 32'h4); look(10, 0);
    curReq = "R7"; drive(2, 0, 5); wr(11, 0, 32'h4); look(10, 0);
    // R8: edge-only overrides level mode
    curReq = "R8"; wr(0, 0, 32'h3); drive(2, 1, 5); wr(11, 0, 32'h4); step(4); look(10, 0);
    drive(2, 0, 5); wr(0, 0, 32'h1);
    // R9: masked line and disabled block
    curReq = "R9"; wr(2, 0, 32'h20); drive(5, 1, 5); drive(5, 0, 5); look(10, 0);
    wr(0, 0, 32'h0); drive(6, 1, 5); drive(6, 0, 5); look(10, 0); look(1, 0);
    wr(0, 0, 32'h1);
    // R1: last line, word 1 bit 7
    curReq = "R1"; wr(3, 1, 32'h80); wr(8, 1, 32'h80); wr(6, 1, 32'h80); look(10, 1);
    drive(39, 1, 5); look(10, 1);
    // R12: masking a pending line drops wake
    curReq = "R12"; wr(2, 1, 32'h80); look(10, 1); wr(3, 1, 32'h80); look(10, 1);
    // R11: soft reset returns to defaults
    curReq = "R11"; drive(3, 1, 5); wr(0, 0, 32'h5); look(0, 0); look(10, 0); look(10, 1);
    look(1, 0); look(4, 0); look(7, 0);
    step(5);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      errCount++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vecCount, errCount);
      $finish;
    end
  end

endmodule